// File: doc/BRIEF.md
# Round-Robin Multi-Channel Serial ADC Sampler

This block is a receive-only serial master that polls up to eight external ADCs one after another. Every ADC drives the same shared data input, so the block selects one device per frame. It generates a serial clock from the system clock and shifts in one conversion, most significant bit first. It then stores the result, right-aligned, in that channel's result register and moves on to the next channel. A host configures the block and reads results through a small synchronous register port.

Three framings are available. The quad framing serves a single four-channel converter whose channel is picked by two select lines driven directly, with 12-bit results. The two decoder framings serve one single-channel converter per slot, with 15-bit or 16-bit results. In those framings the slot number goes out as a 3-bit code to an external 3-to-8 chip-select decoder. A common active-low enable frames every transfer. The enable stays high for a fixed pause between frames so that each converter can start its next conversion.

Register map, all 16 bits wide. Addresses 0 to 7 are the result registers of slots 0 to 7. Address 8 is the control word: bit 0 is run, bits 2:1 are the framing, bits 5:3 are the index of the last active slot, and bits 15:6 are the clock divider. Address 9 is the status register, with one valid flag per slot in bits 7:0.

Top module: `rr_adc_sampler`

## Requirements
- R1: After a synchronous reset, adc_cs_n is 1, adc_sclk is 0, the control word reads 0, every valid flag reads 0 and every result register reads 0.
- R2: While run is 1, the slots are visited in order 0, 1, … up to the last active index, and the order then wraps to 0. The first frame after run is set always uses slot 0.
- R3: Framing code 0 keeps the low 12 bits of a frame and code 1 keeps the low 15 bits. Codes 2 and 3 keep all 16 bits. Bits above the sample width read as 0.
- R4: During a frame, adc_sel holds the slot number and does not change. In framing 0, adc_sel[2] is 0 and adc_sel[1:0] select one of four channels directly. In the other framings, adc_sel is the 3-bit decoder code.
- R5: Each frame drives adc_cs_n low for 16 serial clock periods. adc_sclk is low while adc_cs_n is high. The serial clock toggles once every divider+1 system clocks, and adc_miso is captured on its rising edge, MSB first.
- R6: adc_cs_n stays high for at least 4·(divider+1) system clocks between two frames, which is two serial clock periods.
- R7: A write of the last-slot field above 3 in framing 0 is stored as 3. In the other framings any value from 0 to 7 is stored unchanged. The control word reads back the stored value.
- R8: A slot's valid flag is set when a new result is stored in that slot. The flag is cleared only by a host read of that slot's result register. Reading the status register clears nothing.
- R9: Writing run as 0 lets the current frame finish and store its result, and then no further frame starts. Setting run again restarts at slot 0.
- R10: host_rdata shows the addressed register on the clock edge that samples host_rd and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| adc_sclk | output | 1 | Serial clock to the ADCs |
| adc_cs_n | output | 1 | Active-low frame enable |
| adc_sel | output | 3 | Direct channel select (framing 0) or decoder code |
| adc_miso | input | 1 | Shared serial data from all ADCs |

## Verification
Read data is due one clock after host_rd, so the bench raises the strobe at a falling clock edge and samples host_rdata at the next falling edge. A result and its valid flag are stored one clock after the final falling serial clock edge of a frame. That moment depends on the divider, so the bench does not count cycles for it. It polls the status register until every active slot is flagged, and it checks the stored values only after a stop has drained the last frame. The inter-frame pause is measured at falling clock edges as the number of cycles adc_cs_n stays high, and each frame's slot is logged when adc_cs_n falls. The order and the pause are then compared with the values the requirements give.

// File: rtl/rr_adc_pkg.sv
package rr_adc_pkg;

    localparam int NUM_SLOTS   = 8;
    localparam int CH_W        = $clog2(NUM_SLOTS);
    localparam int FRAME_BITS  = 16;
    localparam int REG_W       = 16;
    localparam int ADDR_W      = 4;
    localparam int DIV_W       = 10;
    localparam int GAP_PERIODS = 2;
    localparam int QUAD_LAST   = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_SLOTS);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(NUM_SLOTS + 1);

    typedef enum logic [1:0] {
        MODE_QUAD  = 2'd0,
        MODE_DEC15 = 2'd1,
        MODE_DEC16 = 2'd2,
        MODE_DEC16X = 2'd3
    } mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CH_W-1:0]  last;
        mode_e            mode;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic                  we;
        logic [CH_W-1:0]       ch;
        logic [FRAME_BITS-1:0] data;
    } sample_t;

    function automatic logic [FRAME_BITS-1:0] sample_mask(input mode_e m);
        case (m)
            MODE_QUAD:  return FRAME_BITS'(16'h0FFF);
            MODE_DEC15: return FRAME_BITS'(16'h7FFF);
            default:    return '1;
        endcase
    endfunction

    function automatic logic [CH_W-1:0] clamp_last(input logic [CH_W-1:0] req, input mode_e m);
        if (m == MODE_QUAD && req > CH_W'(QUAD_LAST))
            return CH_W'(QUAD_LAST);
        return req;
    endfunction

endpackage

// File: rtl/rr_tick.sv
module rr_tick #(
    parameter int DIV_W = rr_adc_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || !en || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rr_seq.sv
module rr_seq
    import rr_adc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  mode_e           mode,
    input  logic [CH_W-1:0] last,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            sclk,
    output logic            cs_n,
    output logic [CH_W-1:0] sel,
    output sample_t         smp
);
    localparam int FRAME_TICKS = 2 * FRAME_BITS;
    localparam int GAP_TICKS   = 2 * GAP_PERIODS;
    localparam int TCNT_W      = $clog2(FRAME_TICKS);

    typedef enum logic [1:0] { ST_IDLE, ST_GAP, ST_SHIFT } state_e;

    state_e                state_q;
    logic [TCNT_W-1:0]     tcnt_q;
    logic [CH_W-1:0]       ch_q;
    logic [FRAME_BITS-1:0] shreg_q;

    assign busy = (state_q != ST_IDLE);

    generate
        if (CH_W > 2) begin : g_sel_wide
            assign sel = (mode == MODE_QUAD) ? {{(CH_W-2){1'b0}}, ch_q[1:0]} : ch_q;
        end else begin : g_sel_narrow
            assign sel = ch_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            ch_q    <= '0;
            shreg_q <= '0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            smp     <= '0;
        end else begin
            smp.we <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    tcnt_q <= '0;
                    sclk   <= 1'b0;
                    cs_n   <= 1'b1;
                    if (run) begin
                        state_q <= ST_GAP;
                        ch_q    <= '0;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (tcnt_q == TCNT_W'(GAP_TICKS - 1)) begin
                            state_q <= ST_SHIFT;
                            tcnt_q  <= '0;
                            cs_n    <= 1'b0;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (!sclk)
                            shreg_q <= {shreg_q[FRAME_BITS-2:0], miso};
                        if (tcnt_q == TCNT_W'(FRAME_TICKS - 1)) begin
                            cs_n     <= 1'b1;
                            tcnt_q   <= '0;
                            smp.we   <= 1'b1;
                            smp.ch   <= ch_q;
                            smp.data <= shreg_q & sample_mask(mode);
                            if (run) begin
                                state_q <= ST_GAP;
                                ch_q    <= (ch_q >= last) ? '0 : ch_q + 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rr_regs.sv
module rr_regs
    import rr_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    input  sample_t           smp,
    output ctrl_t             ctrl,
    output logic [NUM_SLOTS-1:0] vld,
    output logic [REG_W-1:0]  host_rdata
);
    logic [FRAME_BITS-1:0] res [NUM_SLOTS];
    ctrl_t                 wr_word;

    assign wr_word = ctrl_t'(host_wdata);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [FRAME_BITS-1:0] res_r;
        logic                  vld_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_r <= '0;
                vld_r <= 1'b0;
            end else if (smp.we && smp.ch == CH_W'(i)) begin
                res_r <= smp.data;
                vld_r <= 1'b1;
            end else if (host_rd && host_addr == ADDR_W'(i)) begin
                vld_r <= 1'b0;
            end
        end
        assign res[i] = res_r;
        assign vld[i] = vld_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (host_wr && host_addr == ADDR_CTRL) begin
            ctrl      <= wr_word;
            ctrl.last <= clamp_last(wr_word.last, wr_word.mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            if (host_addr < ADDR_W'(NUM_SLOTS))
                host_rdata <= REG_W'(res[host_addr[CH_W-1:0]]);
            else if (host_addr == ADDR_CTRL)
                host_rdata <= REG_W'(ctrl);
            else if (host_addr == ADDR_STAT)
                host_rdata <= REG_W'(vld);
            else
                host_rdata <= '0;
        end
    end
endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler
    import rr_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              adc_sclk,
    output logic              adc_cs_n,
    output logic [CH_W-1:0]   adc_sel,
    input  logic              adc_miso
);
    ctrl_t                ctrl_q;
    sample_t              smp;
    logic [NUM_SLOTS-1:0] vld_q;
    logic                 busy;
    logic                 tick;

    rr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .smp        (smp),
        .ctrl       (ctrl_q),
        .vld        (vld_q),
        .host_rdata (host_rdata)
    );

    rr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    rr_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .mode (ctrl_q.mode),
        .last (ctrl_q.last),
        .tick (tick),
        .miso (adc_miso),
        .busy (busy),
        .sclk (adc_sclk),
        .cs_n (adc_cs_n),
        .sel  (adc_sel),
        .smp  (smp)
    );
endmodule

// File: rtl/rr_adc_checker.sv
module rr_adc_checker
    import rr_adc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 sclk,
    input logic [CH_W-1:0]      sel,
    input mode_e                mode,
    input logic [CH_W-1:0]      last,
    input logic [DIV_W-1:0]     div,
    input sample_t              smp,
    input logic [NUM_SLOTS-1:0] vld
);
    localparam int GAP_W = DIV_W + 4;

    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] gap_need;

    assign gap_need = (GAP_W'(div) + GAP_W'(1)) * GAP_W'(2 * GAP_PERIODS);

    always_ff @(posedge clk) begin
        if (rst)
            gap_cnt <= '0;
        else if (!cs_n)
            gap_cnt <= '0;
        else if (gap_cnt != '1)
            gap_cnt <= gap_cnt + 1'b1;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> (cs_n && !sclk));

    assert_sclk_low_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_sel_stable_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(sel));

    assert_quad_sel_direct_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && mode == MODE_QUAD) |-> (sel <= CH_W'(QUAD_LAST)));

    assert_gap_length_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (gap_cnt >= gap_need));

    assert_last_clamped_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUAD) |-> (last <= CH_W'(QUAD_LAST)));

    assert_valid_set_R8: assert property (@(posedge clk) disable iff (rst)
        smp.we |=> vld[$past(smp.ch)]);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (smp.we && mode == MODE_QUAD) |-> (smp.data[FRAME_BITS-1:12] == '0));
endmodule

bind rr_adc_sampler rr_adc_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .cs_n (adc_cs_n),
    .sclk (adc_sclk),
    .sel  (adc_sel),
    .mode (ctrl_q.mode),
    .last (ctrl_q.last),
    .div  (ctrl_q.div),
    .smp  (smp),
    .vld  (vld_q)
);

// File: tb/test_rr_adc_sampler.sv
module test_rr_adc_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  last_wr;
        logic [2:0]  last_exp;
        logic [9:0]  div;
        logic [15:0] seed;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd7, 3'd3, 10'd0, 16'hF00F},
        '{2'd0, 3'd1, 3'd1, 10'd1, 16'h8421},
        '{2'd1, 3'd7, 3'd7, 10'd0, 16'hFFFF},
        '{2'd2, 3'd4, 3'd4, 10'd2, 16'h9C3A},
        '{2'd1, 3'd0, 3'd0, 10'd0, 16'h7E01},
        '{2'd3, 3'd5, 3'd5, 10'd1, 16'h5AA5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        adc_sclk;
    logic        adc_cs_n;
    logic [2:0]  adc_sel;
    logic        adc_miso = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [15:0] adc_sh = '0;
    logic [15:0] cur_seed = '0;
    int          log_n = 0;
    logic [2:0]  log_q [64];
    int          hi_cnt = 0;
    int          min_gap = 1 << 30;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rr_adc_sampler i_rr_adc_sampler (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .adc_sclk   (adc_sclk),
        .adc_cs_n   (adc_cs_n),
        .adc_sel    (adc_sel),
        .adc_miso   (adc_miso)
    );

    function automatic logic [15:0] adc_word(input logic [2:0] ch, input logic [15:0] seed);
        return seed ^ (16'h2111 * {13'd0, ch}) ^ {ch, 13'd0};
    endfunction

    function automatic logic [15:0] width_mask(input logic [1:0] mode);
        case (mode)
            2'd0:    return 16'h0FFF;
            2'd1:    return 16'h7FFF;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [15:0] ctrl_word(input logic [1:0] mode, input logic [2:0] last,
                                              input logic [9:0] div, input logic run);
        return {div, last, mode, run};
    endfunction

    // serial ADC model: one word per frame, MSB first, shifted after each falling edge
    always @(negedge adc_cs_n) begin
        if (log_n < 64) log_q[log_n] = adc_sel;
        log_n  = log_n + 1;
        adc_sh = adc_word(adc_sel, cur_seed);
        adc_miso = adc_sh[15];
    end

    always @(negedge adc_sclk) begin
        if (adc_cs_n === 1'b0) begin
            adc_sh   = {adc_sh[14:0], 1'b0};
            adc_miso = adc_sh[15];
        end
    end

    always @(negedge clk) begin
        if (adc_cs_n === 1'b1) begin
            hi_cnt = hi_cnt + 1;
        end else begin
            if (hi_cnt > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
            hi_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic clear_all();
        logic [15:0] d;
        for (int c = 0; c < 8; c++) reg_rd(4'(c), d);
    endtask

    task automatic wait_status(input logic [7:0] want, output logic ok);
        logic [15:0] d;
        ok = 1'b0;
        for (int n = 0; n < 2000 && !ok; n++) begin
            reg_rd(4'd9, d);
            if ((d[7:0] & want) == want) ok = 1'b1;
        end
    endtask

    task automatic wait_frames(input int n);
        for (int k = 0; k < 20000 && log_n < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] prev;
        logic        ok;
        int          nch;
        logic [7:0]  full;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", 32'(adc_cs_n), 32'd1);
        check("R1 sclk", 32'(adc_sclk), 32'd0);
        reg_rd(4'd8, d); check("R1 ctrl", 32'(d), 32'd0);
        reg_rd(4'd9, d); check("R1 status", 32'(d), 32'd0);
        reg_rd(4'd3, d); check("R1 result", 32'(d), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            cur_seed = VECS[v].seed;
            nch      = int'(VECS[v].last_exp) + 1;
            full     = 8'((1 << nch) - 1);
            log_n    = 0;
            min_gap  = 1 << 30;
            reg_wr(4'd8, ctrl_word(VECS[v].mode, VECS[v].last_wr, VECS[v].div, 1'b1));
            // R7: clamped count read back
            reg_rd(4'd8, d);
            check("R7 ctrl readback", 32'(d),
                  32'(ctrl_word(VECS[v].mode, VECS[v].last_exp, VECS[v].div, 1'b1)));
            wait_status(full, ok);
            check("R8 valid flags set", 32'(ok), 32'd1);
            reg_wr(4'd8, ctrl_word(VECS[v].mode, VECS[v].last_exp, VECS[v].div, 1'b0));
            repeat (600) @(negedge clk);
            // R2/R4: slot order and select encoding
            ok = 1'b1;
            for (int k = 0; k < log_n && k < 64; k++)
                if (log_q[k] !== 3'(k % nch)) ok = 1'b0;
            check("R2 R4 select order", 32'(ok), 32'd1);
            // R5/R6: pause between frames
            check("R6 gap >= 4*(div+1)", 32'(min_gap >= 4 * (int'(VECS[v].div) + 1)), 32'd1);
            // R3/R5: stored samples, masked to the framing width
            for (int c = 0; c < 8; c++) begin
                reg_rd(4'(c), d);
                if (c < nch)
                    check("R3 R5 sample value", 32'(d),
                          32'(adc_word(3'(c), VECS[v].seed) & width_mask(VECS[v].mode)));
            end
            reg_rd(4'd9, d);
            check("R8 status cleared by reads", 32'(d), 32'd0);
        end

        // R9: stop at frame boundary, restart from slot 0
        cur_seed = 16'h1234;
        log_n = 0;
        reg_wr(4'd8, ctrl_word(2'd2, 3'd7, 10'd0, 1'b1));
        wait_frames(3);
        repeat (10) @(negedge clk);
        reg_wr(4'd8, ctrl_word(2'd2, 3'd7, 10'd0, 1'b0));
        repeat (300) @(negedge clk);
        check("R9 no frame after stop", 32'(log_n), 32'd3);
        check("R9 cs_n idle after stop", 32'(adc_cs_n), 32'd1);
        reg_rd(4'd9, d);
        check("R9 last frame completed", 32'(d), 32'h0007);
        reg_rd(4'd2, d);
        check("R9 last frame data", 32'(d), 32'(adc_word(3'd2, 16'h1234)));
        // R8: reading one slot clears only its flag
        reg_rd(4'd9, d);
        check("R8 status read does not clear", 32'(d), 32'h0003);
        reg_rd(4'd1, d);
        reg_rd(4'd9, d);
        check("R8 single slot cleared", 32'(d), 32'h0001);

        log_n = 0;
        reg_wr(4'd8, ctrl_word(2'd2, 3'd7, 10'd0, 1'b1));
        wait_frames(2);
        check("R9 restart slot 0", 32'(log_q[0]), 32'd0);
        check("R9 restart slot 1", 32'(log_q[1]), 32'd1);
        reg_wr(4'd8, ctrl_word(2'd2, 3'd7, 10'd0, 1'b0));
        repeat (300) @(negedge clk);

        // R10: read data updates one edge after the strobe and then holds
        reg_rd(4'd9, d);
        prev = d;
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'd8;
        #1;
        check("R10 rdata before edge", 32'(host_rdata), 32'(prev));
        @(negedge clk);
        host_rd = 1'b0;
        check("R10 rdata after edge", 32'(host_rdata),
              32'(ctrl_word(2'd2, 3'd7, 10'd0, 1'b0)));
        repeat (3) @(negedge clk);
        check("R10 rdata holds", 32'(host_rdata),
              32'(ctrl_word(2'd2, 3'd7, 10'd0, 1'b0)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule